// File: doc/BRIEF.md
# Floating-Point Issue Occupancy Scheduler

This block sits beside the integer issue stage and decides, cycle by cycle, whether a floating-point operation may be handed to the floating-point pipe. Each accepted operation is modelled as a token that moves through a queue slot, a register-read slot and four execute slots named E1 to E4. E2 is an iterative unit: a token stays there for a number of cycles fixed by its operation class. The pipe never stalls internally. Instead the scheduler holds `issue_ready` low whenever an operation offered now would arrive at E2 while E2 is still owned, or when it would announce its result in a cycle already claimed by an earlier token.

For every accepted token the block pulses `res_valid` together with the token's tag in the cycle its result becomes usable by a dependent instruction. That cycle depends on the class: stores are announced from E1, fast operations and moves out of the unit from E2, loads from E3, and all other arithmetic from E4. Moves of a double word between register files take two consecutive slots in every stage. The issue controller has two named states. In `ISS_OPEN` it may accept; the transition `OPEN->PAIR` is taken on accepting a double-word move. `ISS_PAIR` lasts one cycle, during which the second half is injected and nothing is accepted, and it always returns by `PAIR->OPEN`. The E2 holder has the states `E2_IDLE` and `E2_BUSY`. It takes `IDLE->BUSY` when a token arrives from E1, stays in `BUSY->BUSY` while cycles remain, and takes `BUSY->IDLE` or `BUSY->BUSY` (a reload) on the last cycle.

Top module: `fpq_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_valid` is 0. With nothing in flight, `issue_ready` is 1 for every class code.
- R2: A token accepted at the clock edge that ends cycle t is in the queue slot in cycle t+1, register read in t+2, E1 in t+3, and E2 from t+4 onward. After E2 it is in E3 for one cycle and then E4 for one cycle. Tokens never overtake one another.
- R3: `in_class` encodes the E2 hold time. Codes 0 (add/sub), 1 (single multiply), 7 (compare/abs/copy/conditional move), 8 (move into, single), 9 (move into, double), 10 (move out, single), 11 (move out, double), 12 (load) and 13 (store) hold E2 for 1 cycle. Code 2 (double multiply) holds it 2 cycles, 3 (single multiply-accumulate) 3 cycles, and 4 (double multiply-accumulate) 4 cycles. Code 5 (single divide/sqrt) holds it DIVS_HOLD cycles and code 6 (double divide/sqrt) DIVD_HOLD cycles.
- R4: With hold h, a token accepted at the end of cycle t is announced (`res_valid`=1, `res_tag`=its tag) in the following cycle. Code 13 is announced in t+3. Codes 7, 10 and 11 are announced in t+4. Code 12 is announced in t+4+h. Every other code is announced in t+5+h.
- R5: `issue_ready` is 0 in cycle t if any earlier token still occupies E2 in cycle t+4.
- R6: Codes 9 and 11 occupy two consecutive slots in each stage. `issue_ready` is 0 in the cycle after such a token is accepted, and E2 is reserved for one extra cycle.
- R7: `issue_ready` is 0 if the announcement cycle of the offered class is already claimed, so at most one announcement occurs per cycle.
- R8: No token is taken when `in_valid` is 0 or `issue_ready` is 0. Such a cycle produces no later announcement and reserves nothing.
- R9: Class codes 14 and 15 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is offered this cycle |
| in_class | input | 4 | Operation class code (see R3) |
| in_tag | input | TAG_W | Destination tag of the offered operation |
| issue_ready | output | 1 | Offered operation would be accepted this cycle |
| res_valid | output | 1 | A result becomes usable this cycle |
| res_tag | output | TAG_W | Tag of the announced result |

## Verification
The bench builds the block with DIVS_HOLD=5, DIVD_HOLD=9 and TAG_W=4. These short divide holds let a divide stall, its release, and a following collision with the announcement slot all fit within a few dozen cycles. They also let a long pseudo-random stream pass through many E2 stall episodes. The 4-bit tag wraps often, so tag mix-ups between neighbouring tokens become visible. A behavioural model built on absolute cycle numbers predicts `issue_ready`, `res_valid` and `res_tag` in every cycle, including the pair cycle of double moves and refusals caused by announcement-slot conflicts.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

    // Stage from which a token's result is announced
    typedef enum logic [2:0] {
        AP_NONE = 3'd0,
        AP_E1   = 3'd1,
        AP_E2   = 3'd2,
        AP_E3   = 3'd3,
        AP_E4   = 3'd4
    } ann_pt_e;

    typedef enum logic {
        ISS_OPEN = 1'b0,
        ISS_PAIR = 1'b1
    } iss_state_e;

    typedef enum logic {
        E2_IDLE = 1'b0,
        E2_BUSY = 1'b1
    } e2_state_e;

    localparam logic [3:0] CL_ADD   = 4'd0;
    localparam logic [3:0] CL_MULS  = 4'd1;
    localparam logic [3:0] CL_MULD  = 4'd2;
    localparam logic [3:0] CL_MACS  = 4'd3;
    localparam logic [3:0] CL_MACD  = 4'd4;
    localparam logic [3:0] CL_DIVS  = 4'd5;
    localparam logic [3:0] CL_DIVD  = 4'd6;
    localparam logic [3:0] CL_FAST  = 4'd7;
    localparam logic [3:0] CL_MTS   = 4'd8;
    localparam logic [3:0] CL_MTD   = 4'd9;
    localparam logic [3:0] CL_MFS   = 4'd10;
    localparam logic [3:0] CL_MFD   = 4'd11;
    localparam logic [3:0] CL_LOAD  = 4'd12;
    localparam logic [3:0] CL_STORE = 4'd13;

endpackage

// File: rtl/fpq_class_dec.sv
module fpq_class_dec
    import fpq_pkg::*;
#(
    parameter int DIVS_HOLD = 14,
    parameter int DIVD_HOLD = 28,
    parameter int HOLD_W    = 5,
    parameter int DLY_W     = 6
) (
    input  logic [3:0]        cls,
    output logic [HOLD_W-1:0] hold,
    output ann_pt_e           ann_pt,
    output logic              dbl,
    output logic [DLY_W-1:0]  dly
);

    always_comb begin
        hold   = HOLD_W'(1);
        ann_pt = AP_E4;
        dbl    = 1'b0;
        case (cls)
            CL_MULD:  hold = HOLD_W'(2);
            CL_MACS:  hold = HOLD_W'(3);
            CL_MACD:  hold = HOLD_W'(4);
            CL_DIVS:  hold = HOLD_W'(DIVS_HOLD);
            CL_DIVD:  hold = HOLD_W'(DIVD_HOLD);
            CL_FAST:  ann_pt = AP_E2;
            CL_MTD:   dbl = 1'b1;
            CL_MFS:   ann_pt = AP_E2;
            CL_MFD: begin
                ann_pt = AP_E2;
                dbl    = 1'b1;
            end
            CL_LOAD:  ann_pt = AP_E3;
            CL_STORE: ann_pt = AP_E1;
            default:  ;
        endcase
    end

    // Cycles from acceptance to announcement
    always_comb begin
        unique case (ann_pt)
            AP_E1:   dly = DLY_W'(3);
            AP_E2:   dly = DLY_W'(4);
            AP_E3:   dly = DLY_W'(hold) + DLY_W'(4);
            default: dly = DLY_W'(hold) + DLY_W'(5);
        endcase
    end

endmodule

// File: rtl/fpq_issue_ctl.sv
module fpq_issue_ctl
    import fpq_pkg::*;
#(
    parameter int HOLD_W = 5,
    parameter int DLY_W  = 6,
    parameter int REM_W  = 5,
    parameter int SLOTS  = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [HOLD_W-1:0] hold,
    input  logic              dbl,
    input  logic [DLY_W-1:0]  dly,
    output logic              issue_ready,
    output logic              accept,
    output logic              shadow,
    output logic              ann_now
);

    iss_state_e        state_q, state_d;
    logic [REM_W-1:0]  e2_rem_q;
    logic [SLOTS-1:0]  slot_q;
    logic              e2_clear;
    logic              slot_free;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ISS_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ISS_OPEN: if (accept && dbl) state_d = ISS_PAIR;
            ISS_PAIR: state_d = ISS_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        e2_clear    = e2_rem_q < REM_W'(4);
        slot_free   = !slot_q[dly];
        issue_ready = (state_q == ISS_OPEN) && e2_clear && slot_free;
        accept      = in_valid && issue_ready;
        shadow      = (state_q == ISS_PAIR);
        ann_now     = slot_q[0];
    end

    // E2 reservation horizon and announcement slot map
    always_ff @(posedge clk) begin
        if (rst) begin
            e2_rem_q <= '0;
            slot_q   <= '0;
        end else begin
            if (accept)
                e2_rem_q <= REM_W'(hold) + REM_W'(2) + REM_W'(dbl);
            else if (e2_rem_q != '0)
                e2_rem_q <= e2_rem_q - REM_W'(1);
            slot_q <= (slot_q >> 1) |
                      (accept ? (SLOTS'(1) << (dly - DLY_W'(1))) : '0);
        end
    end

endmodule

// File: rtl/fpq_stage_pipe.sv
module fpq_stage_pipe
    import fpq_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int HOLD_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_vld,
    input  logic              shadow,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic [HOLD_W-1:0] acc_hold,
    input  ann_pt_e           acc_ap,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag
);

    localparam int FRONT = 3;   // queue, register read, E1

    logic              f_vld  [FRONT];
    logic [TAG_W-1:0]  f_tag  [FRONT];
    logic [HOLD_W-1:0] f_hold [FRONT];
    ann_pt_e           f_ap   [FRONT];

    e2_state_e         e2_st;
    logic [TAG_W-1:0]  e2_tag;
    logic [HOLD_W-1:0] e2_cnt;
    ann_pt_e           e2_ap;
    logic              e2_first;
    logic              e2_last;

    logic              e3_vld, e4_vld;
    logic [TAG_W-1:0]  e3_tag, e4_tag;
    ann_pt_e           e3_ap, e4_ap;

    logic [3:0]        hit;

    assign e2_last = (e2_st == E2_BUSY) && (e2_cnt <= HOLD_W'(1));

    // Queue, register read and E1 move every cycle
    genvar gi;
    generate
        for (gi = 0; gi < FRONT; gi++) begin : g_front
            always_ff @(posedge clk) begin
                if (rst) begin
                    f_vld[gi]  <= 1'b0;
                    f_tag[gi]  <= '0;
                    f_hold[gi] <= HOLD_W'(1);
                    f_ap[gi]   <= AP_NONE;
                end else if (gi == 0) begin
                    f_vld[gi]  <= acc_vld || shadow;
                    f_tag[gi]  <= shadow ? f_tag[0] : acc_tag;
                    f_hold[gi] <= shadow ? HOLD_W'(1) : acc_hold;
                    f_ap[gi]   <= shadow ? AP_NONE : acc_ap;
                end else begin
                    f_vld[gi]  <= f_vld[gi-1];
                    f_tag[gi]  <= f_tag[gi-1];
                    f_hold[gi] <= f_hold[gi-1];
                    f_ap[gi]   <= f_ap[gi-1];
                end
            end
        end
    endgenerate

    // E2 holder state register
    always_ff @(posedge clk) begin
        if (rst) begin
            e2_st    <= E2_IDLE;
            e2_tag   <= '0;
            e2_cnt   <= '0;
            e2_ap    <= AP_NONE;
            e2_first <= 1'b0;
        end else begin
            unique case (e2_st)
                E2_IDLE: begin
                    if (f_vld[FRONT-1]) begin
                        e2_st    <= E2_BUSY;
                        e2_tag   <= f_tag[FRONT-1];
                        e2_cnt   <= f_hold[FRONT-1];
                        e2_ap    <= f_ap[FRONT-1];
                        e2_first <= 1'b1;
                    end
                end
                E2_BUSY: begin
                    if (!e2_last) begin
                        e2_cnt   <= e2_cnt - HOLD_W'(1);
                        e2_first <= 1'b0;
                    end else if (f_vld[FRONT-1]) begin
                        e2_tag   <= f_tag[FRONT-1];
                        e2_cnt   <= f_hold[FRONT-1];
                        e2_ap    <= f_ap[FRONT-1];
                        e2_first <= 1'b1;
                    end else begin
                        e2_st    <= E2_IDLE;
                        e2_first <= 1'b0;
                    end
                end
            endcase
        end
    end

    // E3 and E4
    always_ff @(posedge clk) begin
        if (rst) begin
            e3_vld <= 1'b0;
            e4_vld <= 1'b0;
            e3_tag <= '0;
            e4_tag <= '0;
            e3_ap  <= AP_NONE;
            e4_ap  <= AP_NONE;
        end else begin
            e3_vld <= e2_last;
            e3_tag <= e2_tag;
            e3_ap  <= e2_ap;
            e4_vld <= e3_vld;
            e4_tag <= e3_tag;
            e4_ap  <= e3_ap;
        end
    end

    // Announcement outputs
    always_comb begin
        hit[0] = f_vld[FRONT-1] && (f_ap[FRONT-1] == AP_E1);
        hit[1] = (e2_st == E2_BUSY) && e2_first && (e2_ap == AP_E2);
        hit[2] = e3_vld && (e3_ap == AP_E3);
        hit[3] = e4_vld && (e4_ap == AP_E4);
        res_valid = |hit;
        if (hit[0])      res_tag = f_tag[FRONT-1];
        else if (hit[1]) res_tag = e2_tag;
        else if (hit[2]) res_tag = e3_tag;
        else             res_tag = e4_tag;
    end

    // R5: a token leaving E1 never finds E2 with cycles still to run
    assert_e2_free_on_entry_R5: assert property (@(posedge clk) disable iff (rst)
        f_vld[FRONT-1] |-> !((e2_st == E2_BUSY) && !e2_last));

    // R7: at most one stage announces per cycle
    assert_one_announce_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R3: a token that still has cycles left stays in E2 unchanged
    assert_e2_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((e2_st == E2_BUSY) && !e2_last) |=> ((e2_st == E2_BUSY) && $stable(e2_tag)));

endmodule

// File: rtl/fpq_sched.sv
module fpq_sched
    import fpq_pkg::*;
#(
    parameter int TAG_W     = 5,
    parameter int DIVS_HOLD = 14,
    parameter int DIVD_HOLD = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       in_class,
    input  logic [TAG_W-1:0] in_tag,
    output logic             issue_ready,
    output logic             res_valid,
    output logic [TAG_W-1:0] res_tag
);

    localparam int HOLD_W = $clog2(DIVD_HOLD + 1);
    localparam int SLOTS  = DIVD_HOLD + 6;
    localparam int DLY_W  = $clog2(SLOTS);
    localparam int REM_W  = $clog2(DIVD_HOLD + 4);

    logic [HOLD_W-1:0] cls_hold;
    ann_pt_e           cls_ap;
    logic              cls_dbl;
    logic [DLY_W-1:0]  cls_dly;
    logic              accept;
    logic              shadow;
    logic              ann_now;

    fpq_class_dec #(
        .DIVS_HOLD (DIVS_HOLD),
        .DIVD_HOLD (DIVD_HOLD),
        .HOLD_W    (HOLD_W),
        .DLY_W     (DLY_W)
    ) u_dec (
        .cls    (in_class),
        .hold   (cls_hold),
        .ann_pt (cls_ap),
        .dbl    (cls_dbl),
        .dly    (cls_dly)
    );

    fpq_issue_ctl #(
        .HOLD_W (HOLD_W),
        .DLY_W  (DLY_W),
        .REM_W  (REM_W),
        .SLOTS  (SLOTS)
    ) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .hold        (cls_hold),
        .dbl         (cls_dbl),
        .dly         (cls_dly),
        .issue_ready (issue_ready),
        .accept      (accept),
        .shadow      (shadow),
        .ann_now     (ann_now)
    );

    fpq_stage_pipe #(
        .TAG_W  (TAG_W),
        .HOLD_W (HOLD_W)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .acc_vld   (accept),
        .shadow    (shadow),
        .acc_tag   (in_tag),
        .acc_hold  (cls_hold),
        .acc_ap    (cls_ap),
        .res_valid (res_valid),
        .res_tag   (res_tag)
    );

    // R4: the stage pipe announces exactly when the slot map predicted
    assert_res_matches_slot_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid == ann_now);

    // R1: the first cycle after reset is quiet and open
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!res_valid && issue_ready));

endmodule

// File: tb/fpq_sched_tb_top.sv
module fpq_sched_tb_top;

    localparam int TAG_W     = 4;
    localparam int DIVS_HOLD = 5;
    localparam int DIVD_HOLD = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [3:0]       in_class = 4'd0;
    logic [TAG_W-1:0] in_tag = '0;
    logic             issue_ready;
    logic             res_valid;
    logic [TAG_W-1:0] res_tag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int e2_last_cyc = -100;
    int pair_cyc = -100;
    int ann_tab[int];
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    fpq_sched #(
        .TAG_W     (TAG_W),
        .DIVS_HOLD (DIVS_HOLD),
        .DIVD_HOLD (DIVD_HOLD)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_class    (in_class),
        .in_tag      (in_tag),
        .issue_ready (issue_ready),
        .res_valid   (res_valid),
        .res_tag     (res_tag)
    );

    // Class properties taken from R3, R4, R6 and R9
    function automatic int hold_of(int c);
        case (c)
            2: return 2;
            3: return 3;
            4: return 4;
            5: return DIVS_HOLD;
            6: return DIVD_HOLD;
            default: return 1;
        endcase
    endfunction

    function automatic int dly_of(int c);
        case (c)
            13: return 3;
            7, 10, 11: return 4;
            12: return 4 + hold_of(c);
            default: return 5 + hold_of(c);
        endcase
    endfunction

    function automatic int dbl_of(int c);
        return (c == 9 || c == 11) ? 1 : 0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cyc, act, exp);
        end
    endtask

    // One cycle: drive, compare with the model, then let the model advance
    task automatic step(bit v, int c, int tg, string req);
        bit exp_rdy;
        bit exp_val;
        int exp_tag;
        @(negedge clk);
        in_valid = v;
        in_class = 4'(c);
        in_tag   = TAG_W'(tg);
        #2;
        exp_rdy = (cyc != pair_cyc) && (e2_last_cyc <= cyc + 3) &&
                  !ann_tab.exists(cyc + dly_of(c));
        exp_val = ann_tab.exists(cyc);
        exp_tag = exp_val ? ann_tab[cyc] : 0;
        chk(issue_ready == exp_rdy, req, "issue_ready", int'(issue_ready), int'(exp_rdy));
        chk(res_valid == exp_val, req, "res_valid", int'(res_valid), int'(exp_val));
        if (exp_val) begin
            chk(int'(res_tag) == exp_tag, req, "res_tag", int'(res_tag), exp_tag);
            ann_tab.delete(cyc);
        end
        if (v && exp_rdy) begin
            ann_tab[cyc + dly_of(c)] = tg % (1 << TAG_W);
            e2_last_cyc = cyc + 3 + hold_of(c) + dbl_of(c);
            if (dbl_of(c) == 1) pair_cyc = cyc + 1;
        end
        cyc++;
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, req);
    endtask

    // Hold an offer until it is taken
    task automatic offer(int c, int tg, string req);
        for (int i = 0; i < 60; i++) begin
            bit will = (cyc != pair_cyc) && (e2_last_cyc <= cyc + 3) &&
                       !ann_tab.exists(cyc + dly_of(c));
            step(1'b1, c, tg, req);
            if (will) break;
        end
    endtask

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: quiet and open after reset, for every class code
        for (int c = 0; c < 16; c++) step(1'b0, c, 0, "R1");

        // R3, R4: each class alone, then drained
        for (int c = 0; c < 14; c++) begin
            step(1'b1, c, c, "R4");
            idle(20, "R3");
        end

        // R9: codes 14 and 15 behave as code 0
        step(1'b1, 14, 3, "R9");
        idle(12, "R9");
        step(1'b1, 15, 5, "R9");
        idle(12, "R9");

        // R5: a divide blocks the next offer until E2 frees
        step(1'b1, 6, 1, "R5");
        offer(0, 2, "R5");
        offer(5, 3, "R5");
        offer(3, 4, "R5");
        idle(25, "R5");

        // R6: double moves close issue for one cycle
        step(1'b1, 9, 6, "R6");
        step(1'b1, 13, 7, "R6");
        offer(13, 7, "R6");
        step(1'b1, 11, 8, "R6");
        offer(10, 9, "R6");
        idle(15, "R6");

        // R7: a store whose announcement would meet an earlier add is refused
        step(1'b1, 0, 10, "R7");
        idle(2, "R7");
        step(1'b1, 13, 11, "R7");
        offer(13, 11, "R7");
        step(1'b1, 12, 12, "R7");
        step(1'b1, 7, 13, "R7");
        idle(15, "R7");

        // R8: offers with in_valid low leave nothing behind
        for (int c = 0; c < 14; c++) step(1'b0, c, 15, "R8");
        idle(40, "R8");

        // R2: long pseudo-random stream, order and timing
        seed = 7;
        for (int i = 0; i < 1500; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            step(((seed >> 8) % 3) != 0, (seed >> 12) % 16, (seed >> 4) % 16, "R2");
        end
        idle(40, "R2");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule